// File: doc/BRIEF.md
# Attribute-Driven I2C Master Sequencer

This block is a single-master-port I2C controller whose whole bus transaction comes from one control word. The word carries three byte slots. Each slot holds a data byte and a 2-bit attribute that says what to do with that byte: skip it, open or re-open the bus and send it as an address, move it as data and keep the bus, or move it as data and then release the bus. One host write of the word runs the whole sequence without further help. Status flags and an optional interrupt report the outcome.

SCL and SDA are driven open-drain. An output enable of 1 pulls the line low, and the line is sampled back through a synchronizer. The SCL timing comes from a programmable phase divider, so the bit rate scales from a few kHz up to fast-mode rates. Every high phase is timed only from the moment SCL is actually seen high, which lets slaves stretch the clock and lets other masters synchronize with it. A master that finds SDA low while it has released the line stops at once and frees both lines.

After an address byte with R/W = 1, the following data slots are received instead of sent. The received bytes replace the data fields in the word, which the host reads back.

Top module: `i2cseq_top`

## Requirements
- R1: The control word holds NBYTES slots of 10 bits. Slot k sits at bits [10k+9:10k], with its data byte in [7:0] and its attribute in [9:8]. An accepted write processes the slots from the highest index down to slot 0.
- R2: Attribute 00 disables a slot. The slot is skipped with no bus activity, and processing moves on to the next lower slot.
- R3: Attribute 01 (START) produces a start condition when the bus is not owned, or a repeated start with no stop in between when it is owned. The byte is then sent, and its bit 0 is taken as the R/W bit for the slots that follow.
- R4: Attribute 10 (CONT) moves one data byte and keeps the bus afterwards. No stop condition is issued, and when the sequence ends on it SCL stays pulled low.
- R5: Attribute 11 (STOP) moves one data byte and then produces a stop condition that releases both lines.
- R6: After an address with R/W = 1, CONT and STOP slots are received. The master sends ACK after a CONT byte and NACK after a STOP byte. The received byte replaces that slot's data field in ctl_rdata.
- R7: If a written byte (address or data) is not acknowledged, the block issues a stop condition, drops the remaining slots and sets nack_err.
- R8: If SDA reads low during a bit the master leaves released, or if the bus is found busy when a start is due, arb_lost is set, both lines are released, no stop is generated and the sequence ends.
- R9: Each SCL phase lasts div_cfg+1 clock cycles. The high phase starts counting only once SCL is sampled high, so a slave that holds SCL low lengthens the bit and does not shorten the high time.
- R10: busy rises on the cycle after an accepted write and falls when the sequence ends. done is set at the end and cleared by the next accepted write.
- R11: irq equals done while irq_en is 1, and stays 0 while irq_en is 0.
- R12: A ctl_wr pulse while busy is 1 is ignored. The sequence in progress and the returned word are not affected.
- R13: After reset both lines are released and busy, done, arb_lost, nack_err and irq are 0. While the bus is not owned and the block is idle, it drives neither line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the control word; starts a sequence when idle |
| ctl_wdata | input | NBYTES*10 | Control word: data and attribute per slot |
| ctl_rdata | output | NBYTES*10 | Current word, with received bytes merged in |
| div_cfg | input | DIV_W | SCL phase length minus one, in clock cycles |
| irq_en | input | 1 | Enables the completion interrupt |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished |
| arb_lost | output | 1 | Arbitration was lost in the last sequence |
| nack_err | output | 1 | A written byte was not acknowledged |
| irq | output | 1 | Completion interrupt |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench builds the block with DIV_W = 8, a divider setting of 3, two synchronizer stages and three slots. That makes each phase four cycles and a byte about 130 cycles, so multi-slot sequences, repeated starts, received bytes and missing acknowledges all complete many times within a short run. A behavioural slave stretches SCL for 15 cycles, which is well beyond the 8-cycle low time, so the wait-for-high timing is really exercised. A second simulated master pulls SDA low during the first address bit to force arbitration loss.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    localparam int SLOT_W = 10;

    typedef enum logic [1:0] {
        ATTR_OFF   = 2'b00,
        ATTR_START = 2'b01,
        ATTR_CONT  = 2'b10,
        ATTR_STOP  = 2'b11
    } attr_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_START,
        ST_BIT,
        ST_STOP
    } state_e;

endpackage

// File: rtl/i2cseq_sync.sv
module i2cseq_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int CHAIN_W = W * STAGES;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    generate
        if (STAGES > 1) begin : g_multi
            always_comb chain_d = {chain_q[CHAIN_W-W-1:0], din};
        end else begin : g_single
            always_comb chain_d = din;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[CHAIN_W-1 -: W];
endmodule

// File: rtl/i2cseq_tick.sv
module i2cseq_tick #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] limit,
    input  logic         restart,
    output logic         tick
);
    logic [W-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == limit);

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (restart || tick) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2cseq_top.sv
module i2cseq_top
    import i2cseq_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int NBYTES      = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ctl_wr,
    input  logic [NBYTES*SLOT_W-1:0] ctl_wdata,
    output logic [NBYTES*SLOT_W-1:0] ctl_rdata,
    input  logic [DIV_W-1:0]         div_cfg,
    input  logic                     irq_en,
    output logic                     busy,
    output logic                     done,
    output logic                     arb_lost,
    output logic                     nack_err,
    output logic                     irq,
    input  logic                     scl_i,
    input  logic                     sda_i,
    output logic                     scl_oe,
    output logic                     sda_oe
);
    localparam int WORD_W = NBYTES * SLOT_W;
    localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

    typedef struct packed {
        state_e            st;
        logic [1:0]        ph;
        logic [IDX_W-1:0]  idx;
        logic [3:0]        bitn;
        logic [7:0]        sh;
        logic [WORD_W-1:0] word;
        attr_e             attr;
        logic              owned;
        logic              rd;
        logic              cur_rd;
        logic              scl_drv;
        logic              sda_drv;
        logic              busy;
        logic              done;
        logic              arb;
        logic              nack;
    } regs_t;

    regs_t q, n;
    logic scl_s, sda_s, tick, restart, adv, fin, out_one;
    logic [SLOT_W-1:0] slot;
    attr_e slot_attr;

    i2cseq_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .dout ({scl_s, sda_s})
    );

    i2cseq_tick #(.W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .limit  (div_cfg),
        .restart(restart),
        .tick   (tick)
    );

    assign slot      = q.word[int'(q.idx)*SLOT_W +: SLOT_W];
    assign slot_attr = attr_e'(slot[9:8]);

    // Level to leave on SDA for the current bit (1 = released).
    always_comb begin
        if (q.bitn != 4'd8) out_one = q.cur_rd ? 1'b1 : q.sh[7];
        else                out_one = q.cur_rd ? (q.attr == ATTR_STOP) : 1'b1;
    end

    always_comb begin
        n       = q;
        restart = 1'b0;
        adv     = 1'b0;
        fin     = 1'b0;
        case (q.st)
            ST_IDLE: begin
                restart = 1'b1;
                if (ctl_wr) begin
                    n.word = ctl_wdata;
                    n.idx  = LAST_IDX;
                    n.busy = 1'b1;
                    n.done = 1'b0;
                    n.arb  = 1'b0;
                    n.nack = 1'b0;
                    n.st   = ST_PICK;
                end
            end
            ST_PICK: begin
                restart = 1'b1;
                n.sh    = slot[7:0];
                n.attr  = slot_attr;
                n.ph    = 2'd0;
                n.bitn  = 4'd0;
                case (slot_attr)
                    ATTR_OFF: adv = 1'b1;
                    ATTR_START: begin
                        n.st     = ST_START;
                        n.rd     = slot[0];
                        n.cur_rd = 1'b0;
                    end
                    default: begin
                        n.st     = ST_BIT;
                        n.cur_rd = q.rd;
                    end
                endcase
            end
            ST_START: begin
                case (q.ph)
                    2'd0: begin
                        n.sda_drv = 1'b0;
                        if (tick) begin
                            n.scl_drv = 1'b0;
                            n.ph      = 2'd1;
                        end
                    end
                    2'd1: begin
                        restart = 1'b1;
                        if (scl_s) n.ph = 2'd2;
                    end
                    2'd2: if (tick) begin
                        if (!sda_s) begin
                            n.arb = 1'b1; n.scl_drv = 1'b0; n.sda_drv = 1'b0;
                            n.owned = 1'b0; fin = 1'b1;
                        end else begin
                            n.sda_drv = 1'b1;
                            n.ph      = 2'd3;
                        end
                    end
                    default: if (tick) begin
                        n.scl_drv = 1'b1;
                        n.owned   = 1'b1;
                        n.st      = ST_BIT;
                        n.ph      = 2'd0;
                    end
                endcase
            end
            ST_BIT: begin
                case (q.ph)
                    2'd0: if (tick) begin
                        n.sda_drv = !out_one;
                        n.ph      = 2'd1;
                    end
                    2'd1: if (tick) begin
                        n.scl_drv = 1'b0;
                        n.ph      = 2'd2;
                    end
                    2'd2: begin
                        restart = 1'b1;
                        if (scl_s) n.ph = 2'd3;
                    end
                    default: if (tick) begin
                        if (q.bitn != 4'd8 && !q.cur_rd && !q.sda_drv && !sda_s) begin
                            n.arb = 1'b1; n.scl_drv = 1'b0; n.sda_drv = 1'b0;
                            n.owned = 1'b0; fin = 1'b1;
                        end else begin
                            n.scl_drv = 1'b1;
                            n.ph      = 2'd0;
                            if (q.bitn != 4'd8) begin
                                n.sh   = {q.sh[6:0], sda_s};
                                n.bitn = q.bitn + 4'd1;
                            end else begin
                                if (q.cur_rd) n.word[int'(q.idx)*SLOT_W +: 8] = q.sh;
                                if (!q.cur_rd && sda_s) begin
                                    n.nack = 1'b1;
                                    n.st   = ST_STOP;
                                end else if (q.attr == ATTR_STOP) begin
                                    n.st = ST_STOP;
                                end else begin
                                    adv = 1'b1;
                                end
                            end
                        end
                    end
                endcase
            end
            ST_STOP: begin
                case (q.ph)
                    2'd0: if (tick) begin
                        n.sda_drv = 1'b1;
                        n.ph      = 2'd1;
                    end
                    2'd1: if (tick) begin
                        n.scl_drv = 1'b0;
                        n.ph      = 2'd2;
                    end
                    2'd2: begin
                        restart = 1'b1;
                        if (scl_s) n.ph = 2'd3;
                    end
                    default: if (tick) begin
                        n.sda_drv = 1'b0;
                        n.owned   = 1'b0;
                        if (q.nack) fin = 1'b1;
                        else        adv = 1'b1;
                    end
                endcase
            end
            default: n.st = ST_IDLE;
        endcase
        if (adv) begin
            if (q.idx == '0) begin
                fin = 1'b1;
            end else begin
                n.idx = q.idx - 1'b1;
                n.st  = ST_PICK;
            end
        end
        if (fin) begin
            n.st   = ST_IDLE;
            n.busy = 1'b0;
            n.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign ctl_rdata = q.word;
    assign busy      = q.busy;
    assign done      = q.done;
    assign arb_lost  = q.arb;
    assign nack_err  = q.nack;
    assign irq       = q.done && irq_en;
    assign scl_oe    = q.scl_drv;
    assign sda_oe    = q.sda_drv;

    // R8: after losing the bus, neither line is pulled
    p_arb_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.arb |-> (!q.scl_drv && !q.sda_drv));

    // R7: the two error outcomes never coexist; a refused byte ends with the bus free
    p_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.arb && q.nack));
    p_nack_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.nack && q.done) |-> (!q.owned && !q.scl_drv));

    // R4: during byte transfer SDA only moves while SCL is held low
    p_sda_moves_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_BIT && !$stable(q.sda_drv)) |-> $past(q.scl_drv));

    // R10: an accepted write raises busy; done only follows a busy sequence
    p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.busy && ctl_wr) |=> q.busy);
    p_done_after_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.done) |-> $past(q.busy));
endmodule

// File: tb/test_i2cseq_top.sv
module test_i2cseq_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIVW       = 8;
    localparam int DIVV       = 3;
    localparam int STRETCH    = 15;
    localparam logic [6:0] SLV = 7'h50;
    localparam int EV_S = 32'h1000;
    localparam int EV_P = 32'h2000;
    localparam int NA   = 32'h400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 1'b0;
    logic [29:0] ctl_wdata = '0;
    logic [29:0] ctl_rdata;
    logic [DIVW-1:0] div_cfg = DIVW'(DIVV);
    logic irq_en = 1'b0;
    logic busy, done, arb_lost, nack_err, irq, scl_oe, sda_oe;

    logic slv_scl_low = 1'b0;
    logic slv_sda_low = 1'b0;
    logic oth_sda_low = 1'b0;
    wire  scl_bus = !(scl_oe || slv_scl_low);
    wire  sda_bus = !(sda_oe || slv_sda_low || oth_sda_low);

    i2cseq_top #(.DIV_W(DIVW), .SYNC_STAGES(2), .NBYTES(3)) i_i2cseq_top (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .div_cfg(div_cfg), .irq_en(irq_en),
        .busy(busy), .done(done), .arb_lost(arb_lost), .nack_err(nack_err),
        .irq(irq), .scl_i(scl_bus), .sda_i(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    int linefail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural bus monitor + slave, evaluated every clock
    int ev_q[$];
    int exp_q[$];
    logic ps = 1'b1, pd = 1'b1, bus_owned = 1'b0;
    int bitcnt = 0, rcnt = 0, cyc = 0, hi_start = 0, min_hi = 1000000, stretch_cnt = 0;
    logic first = 1'b0, rw = 1'b0, acked = 1'b0, sending = 1'b0, mack = 1'b0, stretch_en = 1'b0;
    logic [7:0] sh = '0, rdb = '0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n && !busy && !bus_owned && (scl_oe || sda_oe)) linefail++;
        if (stretch_cnt > 0) stretch_cnt--;
        if (ps && scl_bus && pd && !sda_bus) begin
            ev_q.push_back(EV_S); bus_owned = 1'b1;
            bitcnt = 0; first = 1'b1; rcnt = 0; rw = 1'b0; sending = 1'b0;
        end else if (ps && scl_bus && !pd && sda_bus) begin
            ev_q.push_back(EV_P); bus_owned = 1'b0;
            bitcnt = 0; sending = 1'b0; slv_sda_low = 1'b0;
        end else if (!ps && scl_bus) begin
            if (bitcnt < 8) sh = {sh[6:0], sda_bus};
            bitcnt++;
            if (bitcnt == 9) begin
                ev_q.push_back({24'd0, sh} | (sda_bus ? NA : 0));
                mack = !sda_bus;
            end
            hi_start = cyc;
        end else if (ps && !scl_bus) begin
            if (cyc - hi_start < min_hi) min_hi = cyc - hi_start;
            if (stretch_en) stretch_cnt = STRETCH;
            if (bitcnt == 8) begin
                if (first) begin
                    rw = sh[0]; acked = (sh[7:1] == SLV); slv_sda_low = acked;
                end else begin
                    slv_sda_low = !rw;
                end
            end else if (bitcnt == 9) begin
                bitcnt = 0;
                if (first) begin first = 1'b0; sending = rw && acked; end
                else if (rw) sending = mack;
                if (sending) begin
                    rdb = 8'hA5 ^ 8'(rcnt); rcnt++; slv_sda_low = !rdb[7];
                end else begin
                    slv_sda_low = 1'b0;
                end
            end else if (sending && bitcnt >= 1 && bitcnt <= 7) begin
                slv_sda_low = !rdb[7-bitcnt];
            end
        end
        slv_scl_low = (stretch_cnt > 0);
        ps = scl_bus; pd = sda_bus;
    end

    function automatic logic [29:0] mkw(input logic [1:0] a2, input logic [7:0] d2,
                                        input logic [1:0] a1, input logic [7:0] d1,
                                        input logic [1:0] a0, input logic [7:0] d0);
        return {a2, d2, a1, d1, a0, d0};
    endfunction

    // reference model: expected bus events, returned word and error flag
    logic [29:0] exp_word;
    logic exp_nack;
    task automatic build_exp(input logic [29:0] w);
        logic rdm = 1'b0;
        int rc = 0;
        exp_q.delete(); exp_word = w; exp_nack = 1'b0;
        for (int k = 2; k >= 0; k--) begin
            logic [1:0] a = w[k*10+8 +: 2];
            logic [7:0] d = w[k*10 +: 8];
            if (a == 2'b01) begin
                exp_q.push_back(EV_S);
                exp_q.push_back({24'd0, d} | ((d[7:1] == SLV) ? 0 : NA));
                rdm = d[0]; rc = 0;
                if (d[7:1] != SLV) begin
                    exp_q.push_back(EV_P); exp_nack = 1'b1; break;
                end
            end else if (a != 2'b00) begin
                if (rdm) begin
                    logic [7:0] v = 8'hA5 ^ 8'(rc);
                    rc++;
                    exp_q.push_back({24'd0, v} | ((a == 2'b11) ? NA : 0));
                    exp_word[k*10 +: 8] = v;
                end else begin
                    exp_q.push_back({24'd0, d});
                end
                if (a == 2'b11) exp_q.push_back(EV_P);
            end
        end
    endtask

    task automatic cmp_events(input string req);
        int bad = -1;
        for (int i = 0; i < ev_q.size() && i < exp_q.size(); i++)
            if (bad < 0 && ev_q[i] != exp_q[i]) bad = i;
        chk(ev_q.size() == exp_q.size(), req, "event count", ev_q.size(), exp_q.size());
        if (bad >= 0) chk(1'b0, req, $sformatf("event %0d", bad), ev_q[bad], exp_q[bad]);
        else          chk(1'b1, req, "events", 0, 0);
    endtask

    task automatic send(input logic [29:0] w, input logic en);
        @(negedge clk);
        ctl_wdata = w; irq_en = en; ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic wait_done();
        while (!(done && !busy)) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic run_word(input logic [29:0] w, input logic en, input string req);
        ev_q.delete();
        build_exp(w);
        send(w, en);
        wait_done();
        cmp_events(req);
        chk(ctl_rdata == exp_word, req, "returned word", ctl_rdata, exp_word);
        chk(nack_err == exp_nack, req, "nack_err", nack_err, exp_nack);
        chk(arb_lost == 1'b0, req, "arb_lost", arb_lost, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [29:0] w;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk({busy, done, arb_lost, nack_err, irq, scl_oe, sda_oe} == 7'd0, "R13",
            "reset outputs", {busy, done, arb_lost, nack_err, irq, scl_oe, sda_oe}, 0);

        // R1 R3 R4 R5 write sequence, R12 ignored write, R10/R11 status
        w = mkw(2'b01, 8'hA0, 2'b10, 8'h3C, 2'b11, 8'hC3);
        ev_q.delete(); build_exp(w);
        send(w, 1'b1);
        chk(busy && !done, "R10", "busy after write", {busy, done}, 2'b10);
        while (ev_q.size() == 0) @(negedge clk);
        send(mkw(2'b11, 8'hFF, 2'b11, 8'hFF, 2'b11, 8'hFF), 1'b1);
        wait_done();
        cmp_events("R5");
        chk(ctl_rdata == w, "R12", "word after ignored write", ctl_rdata, w);
        chk(irq == 1'b1, "R11", "irq enabled", irq, 1);
        chk(!scl_oe && !sda_oe, "R5", "lines released after stop", {scl_oe, sda_oe}, 0);

        // R2 disabled slot skipped, R11 irq masked, R10 done cleared on accept
        w = mkw(2'b01, 8'hA0, 2'b00, 8'h77, 2'b11, 8'h5A);
        ev_q.delete(); build_exp(w);
        send(w, 1'b0);
        chk(!done && busy, "R10", "done cleared by new write", {busy, done}, 2'b10);
        wait_done();
        cmp_events("R2");
        chk(irq == 1'b0, "R11", "irq masked", irq, 0);

        // R6 read with ACK/NACK and write-back
        run_word(mkw(2'b01, 8'hA1, 2'b10, 8'h00, 2'b11, 8'h00), 1'b0, "R6");

        // R7 address not acknowledged
        run_word(mkw(2'b01, 8'h66, 2'b10, 8'h11, 2'b11, 8'h22), 1'b0, "R7");
        chk(!scl_oe && !sda_oe, "R7", "bus released after nack", {scl_oe, sda_oe}, 0);

        // R4 bus held after CONT, R3 repeated start
        run_word(mkw(2'b01, 8'hA0, 2'b10, 8'h3C, 2'b00, 8'h00), 1'b0, "R4");
        chk(scl_oe == 1'b1, "R4", "SCL held low after CONT end", scl_oe, 1);
        run_word(mkw(2'b01, 8'hA1, 2'b11, 8'h00, 2'b00, 8'h00), 1'b0, "R3");

        // R9 clock stretching
        stretch_en = 1'b1; min_hi = 1000000;
        run_word(mkw(2'b01, 8'hA0, 2'b10, 8'h12, 2'b11, 8'h34), 1'b0, "R9");
        chk(min_hi >= DIVV + 1, "R9", "min SCL high cycles", min_hi, DIVV + 1);
        stretch_en = 1'b0;

        // R8 arbitration loss
        ev_q.delete();
        send(mkw(2'b01, 8'hA0, 2'b11, 8'h55, 2'b00, 8'h00), 1'b0);
        while (ev_q.size() == 0) @(negedge clk);
        oth_sda_low = 1'b1;
        wait_done();
        chk(arb_lost && !nack_err, "R8", "status", {arb_lost, nack_err}, 2'b10);
        chk(!scl_oe && !sda_oe, "R8", "lines released", {scl_oe, sda_oe}, 0);
        chk(ev_q.size() == 1, "R8", "no byte completed", ev_q.size(), 1);
        oth_sda_low = 1'b0;
        repeat (10) @(negedge clk);

        chk(linefail == 0, "R13", "idle cycles with a line pulled", linefail, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule